// File: doc/BRIEF.md
# Stereo Biphase-Mark Audio Transmitter

This block turns a stream of 32-bit stereo sample words into a single IEC 60958 serial line. Software, or a DMA channel, writes samples into a small transmit FIFO through a register bus. Words alternate left then right. A control register starts and stops transmission and selects the reference clock ratio. Two further registers hold the 40 channel-status bits that the block sends, one bit per frame.

The block runs entirely on one reference clock at either 256 or 384 times the sample rate. The ratio select sets the length of one biphase half-cell: 2 or 3 reference cycles. A frame is 128 half-cells (two 32-cell subframes), so the same logic covers every sample rate from 8 kHz to 192 kHz.

Each subframe carries the following:
- a preamble;
- the upper 24 bits of the sample word;
- validity, user and channel-status bits;
- an even-parity bit.

Each subframe is biphase-mark coded. If the FIFO runs dry while started, the block sends silent subframes marked invalid and raises a sticky flag.

Top module: `spdif_tx`

## Requirements
- R1: After synchronous reset (rst_n low), the control register (address 0x04) and both status registers (0x14, 0x18) read zero, and the serial output is low.
- R2: The control register holds bit 0 (start), bit 2 (ratio: 0 selects 2 clocks per half-cell, 1 selects 3) and bit 4 (mode flag). Each reads back as written. Every other written bit is ignored and reads zero; bit 8 is the read-only underrun flag.
- R3: Register 0x14 holds channel-status bits 31:0 and register 0x18 holds bits 39:32 in its low byte. Both read back all 32 written bits, so the upper bits of 0x18 are kept when software rewrites only its low byte by read-modify-write.
- R4: While the start bit is clear, the serial output is low, and it is low from the second clock after start is cleared.
- R5: Every level run on the output is a whole number of half-cells. With ratio 0 the shortest run is 2 clocks; with ratio 1 it is 3 clocks.
- R6: In each subframe, cells 4..27 carry sample bits 31:8, least significant first. Cell 28 is validity, cell 29 (user) is 0, cell 30 is channel status, and cell 31 makes cells 4..31 even parity.
- R7: Each subframe begins with an 8-half-cell preamble starting with a transition, with run lengths in half-cells as follows. B (3,1,1,3) opens the left subframe of frame 0 of each 192-frame block. M (3,3,1,1) opens every other left subframe. W (3,2,1,2) opens every right subframe.
- R8: Both subframes of frame n carry channel-status bit n for n below 40, and 0 for frames 40..191.
- R9: A write to address 0x00 queues bits 31:8 of the word in an 8-deep FIFO. A burst of at least 4 back-to-back writes is absorbed, and samples are sent in write order, alternating left and right.
- R10: When a subframe starts with the FIFO empty while started, its audio is zero and its validity bit is 1, and control bit 8 becomes set and stays set.
- R11: Writing the control register with bit 0 clear while started stops transmission, discards queued samples and clears the underrun flag. The next start opens with a B preamble at frame 0.
- R12: Inside a subframe's data cells, the level changes at every cell boundary, and a cell holding a 1 has an extra change at its middle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 256 or 384 times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| spdif_out | output | 1 | Biphase-mark coded serial line |

## Verification
The line is decoded from its run lengths alone, so preamble type, audio, validity, user, channel-status and parity bits are all recovered without knowing when a frame started.

A long run at the 2-clock ratio with 198 frames of varied samples covers the following:
- the B preamble recurring at frame 192;
- channel-status bits changing across the first 40 frames and falling to zero after them.

A short run at the 3-clock ratio that is allowed to run dry separates correct underrun coding (zero audio, validity set, flag raised) from stale-sample replay. A stop with samples still queued, followed by a fresh start, tells a real flush and frame reset apart from leftovers leaking into the next stream.

// File: rtl/spdif_pkg.sv
// Shared constants and the subframe builder for the biphase-mark transmitter.
// Assumes the subframe is 32 cells and the audio word is 24 bits wide.
package spdif_pkg;
    localparam int AUD_W        = 24;
    localparam int CS_BITS      = 40;
    localparam int BLOCK_FRAMES = 192;
    localparam int DIV_LO       = 2;
    localparam int DIV_HI       = 3;

    localparam logic [4:0] ADR_FIFO = 5'h00;
    localparam logic [4:0] ADR_CTRL = 5'h04;
    localparam logic [4:0] ADR_CSLO = 5'h14;
    localparam logic [4:0] ADR_CSHI = 5'h18;

    // Half-cell levels of each preamble, first half-cell in the MSB,
    // assuming the line was low before it.
    localparam logic [7:0] PRE_B = 8'b11101000;
    localparam logic [7:0] PRE_M = 8'b11100010;
    localparam logic [7:0] PRE_W = 8'b11100100;

    // Lay out one subframe by cell index; cells 3:0 stay unused (preamble).
    function automatic logic [31:0] build_subframe(input logic [AUD_W-1:0] aud,
                                                   input logic vflag,
                                                   input logic cbit);
        logic [31:0] f;
        f        = '0;
        f[27:4]  = aud;
        f[28]    = vflag;
        f[29]    = 1'b0;
        f[30]    = cbit;
        f[31]    = ^f[30:4];
        return f;
    endfunction
endpackage

// File: rtl/spdif_fifo.sv
// Sample FIFO: single clock, write-when-not-full, read-when-not-empty.
// Assumes DEPTH is a power of two; flush empties it in one cycle.
module spdif_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [PW:0]   cnt_q;
    logic do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == (PW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp_q];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    // Pointer and fill-count update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + (PW+1)'(do_push) - (PW+1)'(do_pop);
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= (PW+1)'(DEPTH));
endmodule

// File: rtl/spdif_serializer.sv
// Frame sequencer and biphase-mark encoder. Assumes run rises only while
// counters are cleared, and that the FIFO head is valid whenever not empty.
module spdif_serializer
    import spdif_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               ratio,
    input  logic [CS_BITS-1:0] cs_bits,
    input  logic [AUD_W-1:0]   fifo_dout,
    input  logic               fifo_empty,
    output logic               fifo_pop,
    output logic               underrun_evt,
    output logic               line_out
);
    localparam int DIVW = $clog2(DIV_HI);
    localparam int FRW  = $clog2(BLOCK_FRAMES);

    logic [DIVW-1:0] div_q, div_max;
    logic [5:0]      half_q;
    logic            right_q;
    logic [FRW-1:0]  frame_q;
    logic [31:0]     cur_q;
    logic            pre_ref_q, line_q;
    logic            load, half_tick, cbit;
    logic [7:0]      pat;
    logic [CS_BITS-1:0] cs_shift;

    assign div_max      = ratio ? DIVW'(DIV_HI-1) : DIVW'(DIV_LO-1);
    assign half_tick    = (div_q >= div_max);
    assign load         = run && (div_q == '0) && (half_q == '0);
    assign fifo_pop     = load && !fifo_empty;
    assign underrun_evt = load && fifo_empty;
    assign cs_shift     = cs_bits >> frame_q;
    assign cbit         = (frame_q < FRW'(CS_BITS)) && cs_shift[0];
    assign line_out     = line_q;

    // Choose the preamble for the current subframe.
    always_comb begin
        if (right_q)              pat = PRE_W;
        else if (frame_q == '0)   pat = PRE_B;
        else                      pat = PRE_M;
    end

    // Half-cell, subframe and frame position counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q   <= '0;
            half_q  <= '0;
            right_q <= 1'b0;
            frame_q <= '0;
        end else if (half_tick) begin
            div_q  <= '0;
            half_q <= half_q + 1'b1;
            if (half_q == 6'd63) begin
                right_q <= !right_q;
                if (right_q)
                    frame_q <= (frame_q == FRW'(BLOCK_FRAMES-1)) ? '0 : frame_q + 1'b1;
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Capture the subframe cells at its first half-cell.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cur_q <= '0;
        else if (load)
            cur_q <= build_subframe(fifo_empty ? '0 : fifo_dout, fifo_empty, cbit);
    end

    // Drive the line level for each half-cell.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            line_q    <= 1'b0;
            pre_ref_q <= 1'b0;
        end else if (div_q == '0) begin
            if (half_q < 6'd8) begin
                if (half_q == '0) pre_ref_q <= line_q;
                line_q <= pat[~half_q[2:0]] ^ ((half_q == '0) ? line_q : pre_ref_q);
            end else if (!half_q[0]) begin
                line_q <= !line_q;
            end else begin
                line_q <= cur_q[half_q[5:1]] ? !line_q : line_q;
            end
        end
    end

    // R4
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !line_out);
    // R12
    cell_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && div_q == '0 && half_q >= 6'd8 && !half_q[0]) |=> (line_out != $past(line_out)));
    // R5
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> div_q <= DIVW'(DIV_HI-1));
    // R11
    block_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$past(run)) |-> (half_q == '0 && frame_q == '0 && !right_q));
endmodule

// File: rtl/spdif_tx.sv
// Register bank and top level of the biphase-mark transmitter. Assumes a
// single-cycle write strobe and combinational reads; all state is reset.
module spdif_tx
    import spdif_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int ADDR_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spdif_out
);
    logic        start_q, ratio_q, mode_q, uf_q;
    logic [31:0] cs_lo_q, cs_hi_q;
    logic        wr_ctrl, flush, push;
    logic [AUD_W-1:0] fifo_dout;
    logic        fifo_empty, fifo_full, fifo_pop, underrun_evt;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
    assign push    = bus_wr && (bus_addr == ADDR_W'(ADR_FIFO));
    assign flush   = wr_ctrl && !bus_wdata[0] && start_q;

    // Control and channel-status register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            ratio_q <= 1'b0;
            mode_q  <= 1'b0;
            cs_lo_q <= '0;
            cs_hi_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(ADR_CTRL)) begin
                start_q <= bus_wdata[0];
                ratio_q <= bus_wdata[2];
                mode_q  <= bus_wdata[4];
            end
            if (bus_addr == ADDR_W'(ADR_CSLO)) cs_lo_q <= bus_wdata;
            if (bus_addr == ADDR_W'(ADR_CSHI)) cs_hi_q <= bus_wdata;
        end
    end

    // Sticky underrun flag, cleared by reset or a stop.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) uf_q <= 1'b0;
        else if (underrun_evt) uf_q <= 1'b1;
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADR_CTRL))
            bus_rdata = {23'd0, uf_q, 3'd0, mode_q, 1'b0, ratio_q, 1'b0, start_q};
        else if (bus_addr == ADDR_W'(ADR_CSLO))
            bus_rdata = cs_lo_q;
        else if (bus_addr == ADDR_W'(ADR_CSHI))
            bus_rdata = cs_hi_q;
    end

    spdif_fifo #(.W(AUD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .din   (bus_wdata[31:8]),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    spdif_serializer u_ser (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (start_q),
        .ratio        (ratio_q),
        .cs_bits      ({cs_hi_q[7:0], cs_lo_q}),
        .fifo_dout    (fifo_dout),
        .fifo_empty   (fifo_empty),
        .fifo_pop     (fifo_pop),
        .underrun_evt (underrun_evt),
        .line_out     (spdif_out)
    );

    // R10
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_q && !flush) |=> uf_q);
    // R9
    burst_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fifo_full) |-> start_q);
endmodule

// File: tb/spdif_tx_test.sv
module spdif_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spdif_out;

    always #10 clk = !clk;   // 50 MHz

    spdif_tx uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spdif_out(spdif_out)
    );

    int checks = 0;
    int fails  = 0;
    int cur_r  = 2;
    int min_run = 1000;
    int sess_k = 0;
    string cur_tag = "R9";
    logic [39:0] cs_all;
    logic [27:0] exp_q[$];   // {pre[1:0], v, c, audio[23:0]}; pre 0=B 1=M 2=W

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic push_exp(input logic [31:0] s, input bit uf);
        int frame;
        logic [1:0] pre;
        logic c;
        frame = (sess_k / 2) % 192;
        if (sess_k % 2 == 1) pre = 2'd2;
        else pre = (frame == 0) ? 2'd0 : 2'd1;
        c = (frame < 40) ? cs_all[frame] : 1'b0;
        exp_q.push_back({pre, uf, c, uf ? 24'd0 : s[31:8]});
        sess_k++;
    endtask

    task automatic wr_sample(input logic [31:0] s);
        bus_write(5'h00, s);
        push_exp(s, 1'b0);
    endtask

    task automatic wait_drain(input string req);
        int t = 0;
        while (exp_q.size() != 0 && t < 40000) begin
            @(negedge clk);
            t++;
        end
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    function automatic logic [31:0] smp(input int i);
        return 32'h9E3779B9 * (i + 7) ^ (i << 13);
    endfunction

    // Monitor: run-length decoder and scoreboard compare.
    int run_len = 0;
    logic prev_lvl = 1'b0;
    int st = 0, pre_sum = 0, ntok = 0, pre_second = 0, bitn = 0;
    bit halfp = 0;
    logic [31:0] bits = '0;

    task automatic finish_sub();
        logic [27:0] e;
        logic [1:0] pre;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        pre = (pre_second == 1) ? 2'd0 : (pre_second == 2) ? 2'd2 : 2'd1;
        chk(pre == e[27:26], {"R7 preamble ", cur_tag}, pre, e[27:26]);
        chk(bits[27:4] == e[23:0], {"R6 audio ", cur_tag}, bits[27:4], e[23:0]);
        chk(bits[28] == e[25], "R10 validity", bits[28], e[25]);
        chk(bits[29] == 1'b0, "R6 user", bits[29], 0);
        chk(bits[30] == e[24], "R8 status", bits[30], e[24]);
        chk(^bits[31:4] == 1'b0, "R6 parity", bits, 0);
    endtask

    task automatic handle(input int len);
        int u;
        if (len % cur_r != 0 || len / cur_r > 3) begin
            if (st != 0 && len < 4 * cur_r) chk(0, "R5 run length", len, cur_r);
            st = 0;
            return;
        end
        u = len / cur_r;
        if (len < min_run) min_run = len;
        case (st)
            0: if (u == 3) begin st = 1; pre_sum = 3; ntok = 1; end
            1: begin
                ntok++;
                if (ntok == 2) pre_second = u;
                pre_sum += u;
                if (pre_sum == 8) begin st = 2; bitn = 4; halfp = 0; end
                else if (pre_sum > 8) begin chk(0, "R7 preamble length", pre_sum, 8); st = 0; end
            end
            default: begin
                if (u == 2 && !halfp) begin bits[bitn] = 1'b0; bitn++; end
                else if (u == 1 && halfp) begin bits[bitn] = 1'b1; bitn++; halfp = 0; end
                else if (u == 1) halfp = 1;
                else begin chk(0, "R12 cell coding", u, 2); st = 0; end
                if (st == 2 && bitn == 32) begin finish_sub(); st = 0; end
            end
        endcase
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            run_len = 0; st = 0; prev_lvl = spdif_out;
        end else if (spdif_out == prev_lvl) begin
            run_len++;
        end else begin
            handle(run_len);
            run_len = 1;
            prev_lvl = spdif_out;
        end
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int low_ok;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bus_read(5'h04, rd); chk(rd == 0, "R1 ctrl", rd, 0);
        bus_read(5'h14, rd); chk(rd == 0, "R1 cs low", rd, 0);
        bus_read(5'h18, rd); chk(rd == 0, "R1 cs high", rd, 0);
        chk(spdif_out == 1'b0, "R1 line", spdif_out, 0);
        // R2 control readback and ignored bits
        bus_write(5'h04, 32'h0000_0014);
        bus_read(5'h04, rd); chk(rd == 32'h14, "R2 ctrl", rd, 32'h14);
        bus_write(5'h04, 32'hFFFF_FEEA);
        bus_read(5'h04, rd); chk(rd == 32'h0, "R2 ignored bits", rd, 0);
        // R3 channel status, read-modify-write of the high register
        bus_write(5'h14, 32'hC3A5_0F96);
        bus_write(5'h18, 32'h5A00_12E7);
        bus_read(5'h14, rd); chk(rd == 32'hC3A5_0F96, "R3 cs low", rd, 32'hC3A5_0F96);
        bus_read(5'h18, rd);
        bus_write(5'h18, {rd[31:8], 8'h3D});
        bus_read(5'h18, rd); chk(rd == 32'h5A00_123D, "R3 cs high", rd, 32'h5A00_123D);
        cs_all = {8'h3D, 32'hC3A5_0F96};
        chk(spdif_out == 1'b0, "R4 idle", spdif_out, 0);

        // Long run at ratio 0: block wrap, status bits, ordering.
        cur_r = 2; sess_k = 0; cur_tag = "R9";
        bus_write(5'h04, 32'h10);
        for (int i = 0; i < 4; i++) wr_sample(smp(i));
        bus_write(5'h04, 32'h11);
        for (int i = 4; i < 396; i++) begin
            repeat (64 * cur_r - 2) @(negedge clk);
            wr_sample(smp(i));
        end
        wait_drain("R9 drain");
        repeat (400) @(negedge clk);
        bus_read(5'h04, rd); chk(rd == 32'h111, "R10 flag", rd, 32'h111);
        chk(min_run == 2, "R5 ratio0", min_run, 2);
        bus_write(5'h04, 32'h10);
        @(negedge clk);
        low_ok = 1;
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            if (spdif_out) low_ok = 0;
        end
        chk(low_ok == 1, "R4 stopped", spdif_out, 0);
        bus_read(5'h04, rd); chk(rd == 32'h10, "R11 flag cleared", rd, 32'h10);

        // Short run at ratio 1 that runs dry.
        exp_q.delete(); sess_k = 0; cur_r = 3; min_run = 1000;
        bus_write(5'h04, 32'h14);
        for (int i = 0; i < 4; i++) wr_sample(smp(1000 + i));
        bus_write(5'h04, 32'h15);
        for (int i = 4; i < 16; i++) begin
            repeat (64 * cur_r - 2) @(negedge clk);
            wr_sample(smp(1000 + i));
        end
        for (int i = 0; i < 6; i++) push_exp(32'h0, 1'b1);
        wait_drain("R10 drain");
        bus_read(5'h04, rd); chk(rd == 32'h115, "R10 flag", rd, 32'h115);
        chk(min_run == 3, "R5 ratio1", min_run, 3);

        // Stop with samples queued, then restart: leftovers must not appear.
        for (int i = 0; i < 4; i++) bus_write(5'h00, 32'hFFFF_FF00);
        bus_write(5'h04, 32'h14);
        repeat (10) @(negedge clk);
        exp_q.delete(); sess_k = 0; cur_tag = "R11";
        bus_read(5'h04, rd); chk(rd == 32'h14, "R11 flag cleared", rd, 32'h14);
        wr_sample(smp(2000));
        wr_sample(smp(2001));
        bus_write(5'h04, 32'h15);
        push_exp(32'h0, 1'b1);
        push_exp(32'h0, 1'b1);
        wait_drain("R11 drain");
        bus_write(5'h04, 32'h14);
        repeat (3) @(negedge clk);
        chk(spdif_out == 1'b0, "R4 final idle", spdif_out, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule